// File: doc/BRIEF.md
# Triggered One-Shot Delay Counter

This block is one timer channel that measures out a programmable delay and then fires once. Software places a delay value in a reload register and arms the channel with a self-clearing start strobe. Arming does not start counting. The count starts on the next trigger, which is either a further start strobe or a chosen edge on an external input pin.

On each trigger the reload value is copied into a 16-bit down-counter. The counter then decrements on every tick of a selectable prescaled count clock. When it reaches zero the block raises a single-cycle interrupt pulse. The counter then parks at zero until another trigger arrives. A self-clearing stop strobe disarms the channel and freezes the count. A unit enable holds the whole block cleared while it is low. The counter value can be read on a port at all times.

Top module: `oneshot_delay_timer`

## Requirements
- R1: While `rst_n` is low, and while `unit_en` is low, the block is cleared. The count is 0xFFFF, the reload register is 0, `armed` is 0 and `irq` is 0. A reload write made in such a cycle is lost.
- R2: A start strobe while `armed` is 0 sets `armed` to 1 on the next cycle. It does not load or change the counter.
- R3: While `armed` is 1, either a start strobe or a detected valid input edge is a trigger. A trigger copies the reload register into the counter on the next cycle.
- R4: After a trigger the counter decrements by one on each count tick. The prescaler is a free-running cycle counter that starts at 0 after the block is cleared. With `clk_sel` = s, a tick occurs in every cycle whose low s bits of that counter are all ones. This gives a division by 1, 2, 4 or 8.
- R5: On the tick that finds the counter at 1, or at 0, the counter becomes 0 and `irq` is high for exactly one cycle. Counting then stops until the next trigger. A reload value of 0 therefore fires on the first tick.
- R6: Writing the reload register while counting does not change the count in progress. The new value is used at the next trigger.
- R7: A stop strobe clears `armed` and halts counting, and the counter keeps its value. A stop strobe wins over a start strobe in the same cycle.
- R8: `trig_in` passes through a two-flop synchronizer before edge detection. `edge_sel` selects the valid edge: 0 is rising, 1 is falling, 2 is both and 3 is none. An edge that arrives while `armed` is 0 is ignored.
- R9: A trigger that arrives while a count is in progress restarts the count from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en | input | 1 | Unit enable; low holds the block cleared |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload value to write |
| start_stb | input | 1 | Self-clearing start/arm strobe |
| stop_stb | input | 1 | Self-clearing stop strobe |
| clk_sel | input | 2 | Prescaler select, divide by 2^clk_sel |
| edge_sel | input | 2 | Valid edge: 0 rise, 1 fall, 2 both, 3 none |
| trig_in | input | 1 | External asynchronous trigger input |
| count_out | output | 16 | Current counter value |
| armed | output | 1 | Channel-enable status |
| irq | output | 1 | One-cycle interrupt pulse at zero |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 2-bit prescaler select and one bit of division per select step. All four divide ratios are therefore within eight cycles, and a full count with each prescaler setting fits into a short run. Reload values are kept small in the random phase, so that counts really reach zero and fire. The bench also covers a zero reload, rewrites of the reload register in the middle of a count, retriggers, and a stop strobe in the same cycle as a start strobe.

// File: rtl/odt_pkg.sv
// Package: shared types for the one-shot delay timer.
// Assumes nothing beyond IEEE 1800-2017.
package odt_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_NONE = 2'd3
    } edge_mode_t;
endpackage

// File: rtl/odt_prescaler.sv
// Prescaler: free-running cycle counter that gives a tick every 2^(sel*DIV_STEP) cycles.
// Assumes DIV_STEP >= 1. The counter is cleared whenever clr is high.
module odt_prescaler #(
    parameter int SEL_W    = 2,
    parameter int DIV_STEP = 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NSEL = 1 << SEL_W;
    localparam int PC_W = DIV_STEP * (NSEL - 1);

    logic [PC_W-1:0] pcnt;
    logic [NSEL-1:0] tick_v;

    // Free-running count, restarted when the unit is cleared.
    always_ff @(posedge clk) begin
        if (clr) pcnt <= '0;
        else     pcnt <= pcnt + 1'b1;
    end

    // One candidate tick for each select value.
    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_tick
            if (g == 0) begin : g_div1
                assign tick_v[g] = 1'b1;
            end else begin : g_divn
                assign tick_v[g] = &pcnt[g*DIV_STEP-1:0];
            end
        end
    endgenerate

    assign tick = tick_v[sel];
endmodule

// File: rtl/odt_edge_detect.sv
// Edge detector: synchronizes an asynchronous pin through two flops, then
// flags the edge type chosen by mode. Assumes mode is quasi-static.
module odt_edge_detect
    import odt_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       pin,
    input  edge_mode_t mode,
    output logic       hit
);
    logic sync1, sync2, last;

    // Two-flop synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (clr) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            last  <= 1'b0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            last  <= sync2;
        end
    end

    // Edge qualification by mode.
    always_comb begin
        unique case (mode)
            EDGE_RISE: hit = sync2 & ~last;
            EDGE_FALL: hit = ~sync2 & last;
            EDGE_BOTH: hit = sync2 ^ last;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/odt_count_core.sv
// Count core: arm/stop status, reload register and the down-counter with its
// zero-reach interrupt. Assumes tick and hit are single-cycle qualifiers.
module odt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             start_stb,
    input  logic             stop_stb,
    input  logic             tick,
    input  logic             hit,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_RST = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] reload_q;
    logic             running;
    logic             trigger;

    assign trigger = armed & (start_stb | hit);

    // Reload register, written by software at any time.
    always_ff @(posedge clk) begin
        if (clr)            reload_q <= '0;
        else if (reload_we) reload_q <= reload_wdata;
    end

    // Arm status, run state, counter and interrupt pulse.
    always_ff @(posedge clk) begin
        if (clr) begin
            armed   <= 1'b0;
            running <= 1'b0;
            count   <= CNT_RST;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (stop_stb) begin
                armed   <= 1'b0;
                running <= 1'b0;
            end else if (start_stb && !armed) begin
                armed <= 1'b1;
            end else if (trigger) begin
                count   <= reload_q;
                running <= 1'b1;
            end else if (running && tick) begin
                if (count <= CNT_ONE) begin
                    count   <= '0;
                    irq     <= 1'b1;
                    running <= 1'b0;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/oneshot_delay_timer.sv
// Top: triggered one-shot delay counter channel. Unit enable low acts as a
// synchronous clear of everything. Assumes trig_in may be asynchronous.
module oneshot_delay_timer
    import odt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SEL_W    = 2,
    parameter int DIV_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             start_stb,
    input  logic             stop_stb,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [1:0]       edge_sel,
    input  logic             trig_in,
    output logic [CNT_W-1:0] count_out,
    output logic             armed,
    output logic             irq
);
    logic clr;
    logic tick;
    logic hit;

    // Reset and unit disable clear the same state.
    assign clr = ~rst_n | ~unit_en;

    odt_prescaler #(.SEL_W(SEL_W), .DIV_STEP(DIV_STEP)) u_presc (
        .clk  (clk),
        .clr  (clr),
        .sel  (clk_sel),
        .tick (tick)
    );

    odt_edge_detect u_edge (
        .clk  (clk),
        .clr  (clr),
        .pin  (trig_in),
        .mode (edge_mode_t'(edge_sel)),
        .hit  (hit)
    );

    odt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .clr          (clr),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .start_stb    (start_stb),
        .stop_stb     (stop_stb),
        .tick         (tick),
        .hit          (hit),
        .count        (count_out),
        .armed        (armed),
        .irq          (irq)
    );
endmodule

// File: rtl/odt_checker.sv
// Checker: port-level temporal properties of the delay timer, bound to the top.
module odt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unit_en,
    input logic             start_stb,
    input logic             stop_stb,
    input logic [CNT_W-1:0] count_out,
    input logic             armed,
    input logic             irq
);
    // R1: a disabled unit leaves the block cleared.
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (count_out == '1) && !armed && !irq);

    // R5: the interrupt pulse lasts a single cycle.
    a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: the interrupt only accompanies a zero count.
    a_r5_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count_out == '0));

    // R7: a stop strobe disarms and freezes the count.
    a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && stop_stb) |=> !armed && $stable(count_out));

    // R2: the count never moves while the channel is disarmed.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && !armed) |=> $stable(count_out));
endmodule

bind oneshot_delay_timer odt_checker #(.CNT_W(CNT_W)) u_odt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_en   (unit_en),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .count_out (count_out),
    .armed     (armed),
    .irq       (irq)
);

// File: tb/tb_oneshot_delay_timer.sv
// Bench: directed corner cases plus seeded random stimulus, compared each
// cycle against a behavioural model written from the requirements.
module tb_oneshot_delay_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n, unit_en, reload_we, start_stb, stop_stb, trig_in;
    logic [15:0] reload_wdata;
    logic [1:0]  clk_sel, edge_sel;
    logic [15:0] count_out;
    logic        armed, irq;

    int    n_chk  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    oneshot_delay_timer dut (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .reload_we(reload_we),
        .reload_wdata(reload_wdata), .start_stb(start_stb), .stop_stb(stop_stb),
        .clk_sel(clk_sel), .edge_sel(edge_sel), .trig_in(trig_in),
        .count_out(count_out), .armed(armed), .irq(irq)
    );

    // Reference model state.
    logic [2:0]  m_pc;
    logic        m_s1, m_s2, m_s3, m_en, m_run, m_irq;
    logic [15:0] m_cnt, m_rel;

    function automatic bit f_tick(input logic [2:0] pc, input logic [1:0] s);
        logic [2:0] mask = 3'((1 << s) - 1);
        return (pc & mask) == mask;
    endfunction

    function automatic bit f_edge(input logic cur, input logic old, input logic [1:0] e);
        case (e)
            2'd0:    return cur && !old;
            2'd1:    return !cur && old;
            2'd2:    return cur != old;
            default: return 1'b0;
        endcase
    endfunction

    // Model update, following R1..R9.
    always @(posedge clk) begin
        if (!rst_n || !unit_en) begin
            m_pc <= '0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            m_en <= 0; m_run <= 0; m_irq <= 0; m_cnt <= 16'hFFFF; m_rel <= '0;
        end else begin
            m_pc <= m_pc + 1'b1;
            m_s1 <= trig_in; m_s2 <= m_s1; m_s3 <= m_s2;
            if (reload_we) m_rel <= reload_wdata;
            m_irq <= 1'b0;
            if (stop_stb) begin
                m_en <= 0; m_run <= 0;
            end else if (!m_en) begin
                if (start_stb) m_en <= 1;
            end else if (start_stb || f_edge(m_s2, m_s3, edge_sel)) begin
                m_cnt <= m_rel; m_run <= 1;
            end else if (m_run && f_tick(m_pc, clk_sel)) begin
                if (m_cnt <= 16'd1) begin
                    m_cnt <= 0; m_irq <= 1; m_run <= 0;
                end else m_cnt <= m_cnt - 1'b1;
            end
        end
    end

    task automatic compare();
        n_chk++;
        if (count_out !== m_cnt || armed !== m_en || irq !== m_irq) begin
            n_fail++;
            $display("FAIL %s: count=%h armed=%b irq=%b expected count=%h armed=%b irq=%b",
                     tag, count_out, armed, irq, m_cnt, m_en, m_irq);
        end
    endtask

    // One cycle: check outputs at the falling edge, then leave strobes idle.
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            start_stb = 0; stop_stb = 0; reload_we = 0;
        end
    endtask

    task automatic pulse_start();
        start_stb = 1; step();
    endtask

    task automatic write_reload(input logic [15:0] v);
        reload_we = 1; reload_wdata = v; step();
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; unit_en = 1; reload_we = 0; reload_wdata = 0;
        start_stb = 0; stop_stb = 0; clk_sel = 0; edge_sel = 2'd3; trig_in = 0;
        repeat (3) @(negedge clk);
        tag = "R1 reset";
        step();
        n_chk++;
        if (count_out !== 16'hFFFF || armed !== 0 || irq !== 0) begin
            n_fail++;
            $display("FAIL R1: count=%h armed=%b irq=%b expected FFFF/0/0", count_out, armed, irq);
        end
        rst_n = 1;
        step(2);

        // R1: writes while the unit is disabled are lost; a zero reload then fires at once.
        tag = "R1 disabled write";
        unit_en = 0; write_reload(16'd9); unit_en = 1; step();
        tag = "R2 arm";
        pulse_start(); step(3);
        tag = "R5 zero reload";
        pulse_start(); step(4);

        // R5: short count at divide 1.
        tag = "R5 count to zero";
        write_reload(16'd3); pulse_start(); step(8);

        // R4: each divide ratio.
        tag = "R4 prescale";
        for (int s = 0; s < 4; s++) begin
            clk_sel = 2'(s); write_reload(16'd4); pulse_start(); step(40);
        end
        clk_sel = 0;

        // R6: rewrite during a count.
        tag = "R6 reload rewrite";
        write_reload(16'd10); pulse_start(); step(3);
        write_reload(16'd2); step(12); pulse_start(); step(5);

        // R9: retrigger mid-count.
        tag = "R9 retrigger";
        write_reload(16'd6); pulse_start(); step(3); pulse_start(); step(10);

        // R7: stop mid-count, then stop and start together.
        tag = "R7 stop";
        write_reload(16'd20); pulse_start(); step(4);
        stop_stb = 1; step(); step(5);
        start_stb = 1; stop_stb = 1; step(); step(4);

        // R8: edge modes, with an edge while disarmed.
        tag = "R8 edges";
        edge_sel = 2'd0; trig_in = 1; step(6); trig_in = 0; step(4);
        pulse_start(); write_reload(16'd3);
        for (int e = 0; e < 4; e++) begin
            edge_sel = 2'(e);
            trig_in = 1; step(8); trig_in = 0; step(8);
        end

        // R3/R4/R5 random mix.
        tag = "R3/R4/R5 random";
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare();
            start_stb    = ($urandom_range(0, 29) == 0);
            stop_stb     = ($urandom_range(0, 99) == 0);
            reload_we    = ($urandom_range(0, 19) == 0);
            reload_wdata = 16'($urandom_range(0, 12));
            if ($urandom_range(0, 7) == 0)   trig_in  = ~trig_in;
            if ($urandom_range(0, 199) == 0) clk_sel  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 199) == 0) edge_sel = 2'($urandom_range(0, 3));
            unit_en = ($urandom_range(0, 299) != 0);
        end
        unit_en = 1; start_stb = 0; stop_stb = 0; reload_we = 0;
        step(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule